// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a 4-way set-associative data cache for a 32-bit physical address space. It uses write-back policy. A core issues one longword read or write at a time. The cache answers each request with a single response pulse that says whether the request hit, whether a bus error ended it, and, for reads, which word was read. Each line holds four 32-bit longwords under a 21-bit tag. Each line also keeps a valid flag and a dirty flag, so a line is always invalid, valid-clean or dirty.

On a miss the block first chooses a victim way in the set. If that victim is dirty, the block copies it back as a four-longword write burst. It then fetches the requested line as a four-longword read burst. A line is installed only when all four beats of the read arrive without error. Otherwise the target way is left invalid. The bus side is a plain burst handshake: the block holds a request and a line-aligned address, and the bus transfers one longword per acknowledge or ends the burst with an error.

A one-cycle invalidate-all input drops every line, including dirty ones, without any copyback.

Top module: `wb_dcache`

## Requirements
- R1: An address splits into tag [31:11], set [10:4] and longword select [3:2]. There are 128 sets of 4 ways, and each line holds 4 longwords.
- R2: `reqReady` is high only while no request is in flight, and every accepted request gets exactly one `rspValid` pulse of one cycle. A hit responds one clock edge after the edge that accepted it.
- R3: A line whose valid flag is clear never hits, even if its stored tag equals the request tag.
- R4: A miss fetches the line as a read burst on the line-aligned address. Longword 0 moves first and longword 3 last, one per `busAck`, and the burst holds while neither `busAck` nor `busErr` is high. A clean-victim miss responds 6 edges after acceptance. The line is then valid and clean.
- R5: A write hit updates only the bytes whose `reqByteEn` bit is set (bit i covers data bits 8i+7..8i), marks the line dirty and causes no bus traffic.
- R6: A write miss fills the line first, then merges the write into it and leaves the line dirty.
- R7: The victim is the lowest-numbered invalid way of the set. If there is none, a per-set round-robin pointer names the victim, starting at way 0. The pointer advances by one after each install that used it.
- R8: A dirty victim is written back as a four-longword write burst, in order longword 0 to 3, before the fill. Such a miss responds 10 edges after acceptance. A clean victim is replaced with no write burst.
- R9: A fill that ends on `busErr` at beat k (counting from 0) responds with `rspErr`=1 and `rspHit`=0, k+2 edges after acceptance. It leaves the target way invalid and the other ways untouched.
- R10: A copyback that ends on `busErr` responds with `rspErr`=1 and starts no fill. The victim line stays dirty with its data intact.
- R11: One cycle of `invAll` makes every line invalid and clean without any write burst, so dirty data is discarded.
- R12: After reset all lines are invalid, `reqReady`=1, and `busReq`=0 and `rspValid`=0.
- R13: The bus direction is given by `busWrite` (1 = copyback, 0 = fill). `busErr` ends the current burst at once, and a beat without `busAck` or `busErr` leaves the address and the beat position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| invAll | input | 1 | Invalidate every line, discarding dirty data |
| reqValid | input | 1 | Core request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the longword |
| reqWData | input | 32 | Write data |
| reqByteEn | input | 4 | Byte enables for a write |
| rspValid | output | 1 | One-cycle response pulse |
| rspHit | output | 1 | Request hit the cache |
| rspErr | output | 1 | Request ended by a bus error |
| rspRData | output | 32 | Read data |
| busReq | output | 1 | Burst in progress |
| busWrite | output | 1 | Burst is a copyback |
| busAddr | output | 32 | Line-aligned burst address |
| busWData | output | 32 | Copyback longword for the current beat |
| busRData | input | 32 | Fill longword for the current beat |
| busAck | input | 1 | Current beat transferred |
| busErr | input | 1 | Burst ends with error |

## Verification
A hit is due one edge after the accepting edge. With a bus that acknowledges every cycle, a clean miss is due after 6 edges and a dirty miss after 10. A fill error at beat k is due after k+2 edges, and a copyback error at beat k after k+2 edges. The driver stores the accepting cycle and the expected latency in each scoreboard item, and the monitor compares the measured distance at the falling edge where `rspValid` is seen. Hit, error and data are compared at that same point. Copyback and clean-replacement behaviour is checked through burst counters kept by the bus model, and through data read back after eviction.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;
  localparam int WORD_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int LINE_WORDS = 4;
  localparam int BEAT_W     = $clog2(LINE_WORDS);
  localparam int OFS_W      = BEAT_W + $clog2(BE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_COPYBACK, ST_FILL, ST_INSTALL
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              latchReq;
    logic              latchVictim;
    logic              copyback;
    logic              captureBeat;
    logic              install;
    logic              writeHit;
    logic              loadHitWord;
    logic              killVictim;
    logic [BEAT_W-1:0] beat;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic candDirty;
    logic isWrite;
  } dpStatus_t;
endpackage

// File: rtl/wbdc_datapath.sv
module wbdc_datapath
  import wbdc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7,
  parameter int WAYS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invAll,
  input  dpStrobe_t         strobe,
  output dpStatus_t         status,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWData,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic [WORD_W-1:0] busRData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWData,
  output logic [WORD_W-1:0] rspRData
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_BITS - OFS_W;

  // latched request
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic              writeQ;

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    tagIn;
  logic [BEAT_W-1:0]   wordSel;
  assign setIdx  = addrQ[OFS_W +: SET_BITS];
  assign tagIn   = addrQ[ADDR_W-1 -: TAG_W];
  assign wordSel = addrQ[OFS_W-1 -: BEAT_W];

  // storage
  logic [WORD_W-1:0] dataMem  [SETS][WAYS][LINE_WORDS];
  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];
  logic [WAY_W-1:0]  rrMem    [SETS];
  logic [WORD_W-1:0] fillBuf  [LINE_WORDS];

  logic [WAY_W-1:0] victimQ;
  logic             usedRrQ;

  function automatic logic [WORD_W-1:0] mergeWord(input logic [WORD_W-1:0] oldW,
                                                  input logic [WORD_W-1:0] newW,
                                                  input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = oldW;
    for (int i = 0; i < BE_W; i++)
      if (be[i]) r[i*8 +: 8] = newW[i*8 +: 8];
    return r;
  endfunction

  // tag compare per way
  logic [WAYS-1:0] hitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == tagIn);
  end

  logic [WAY_W-1:0] hitWay, invWay, candWay;
  logic             anyInv, candFromRr;
  always_comb begin
    hitWay = '0;
    invWay = '0;
    anyInv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (!validMem[setIdx][w]) begin
        invWay = WAY_W'(w);
        anyInv = 1'b1;
      end
    end
    candFromRr = !anyInv;
    candWay    = anyInv ? invWay : rrMem[setIdx];
  end

  assign status.hit       = |hitVec;
  assign status.candDirty = validMem[setIdx][candWay] && dirtyMem[setIdx][candWay];
  assign status.isWrite   = writeQ;

  logic [WORD_W-1:0] installWord;
  assign installWord = writeQ ? mergeWord(fillBuf[wordSel], wdataQ, beQ) : fillBuf[wordSel];

  // bus side
  assign busAddr  = strobe.copyback ? {tagMem[setIdx][victimQ], setIdx, {OFS_W{1'b0}}}
                                    : {tagIn, setIdx, {OFS_W{1'b0}}};
  assign busWData = dataMem[setIdx][victimQ][strobe.beat];

  // request, victim and response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      writeQ   <= 1'b0;
      victimQ  <= '0;
      usedRrQ  <= 1'b0;
      rspRData <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWData;
        beQ    <= reqByteEn;
        writeQ <= reqWrite;
      end
      if (strobe.latchVictim) begin
        victimQ <= candWay;
        usedRrQ <= candFromRr;
      end
      if (strobe.loadHitWord) rspRData <= dataMem[setIdx][hitWay][wordSel];
      else if (strobe.install) rspRData <= installWord;
    end
  end

  // line state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        rrMem[s]    <= '0;
      end
    end else begin
      if (strobe.install && usedRrQ) rrMem[setIdx] <= rrMem[setIdx] + WAY_W'(1);
      if (invAll) begin
        for (int s = 0; s < SETS; s++) begin
          validMem[s] <= '0;
          dirtyMem[s] <= '0;
        end
      end else begin
        if (strobe.install) begin
          validMem[setIdx][victimQ] <= 1'b1;
          dirtyMem[setIdx][victimQ] <= writeQ;
        end
        if (strobe.writeHit) dirtyMem[setIdx][hitWay] <= 1'b1;
        if (strobe.killVictim) begin
          validMem[setIdx][victimQ] <= 1'b0;
          dirtyMem[setIdx][victimQ] <= 1'b0;
        end
      end
    end
  end

  // tags, data and fill buffer
  always_ff @(posedge clk) begin
    if (strobe.captureBeat) fillBuf[strobe.beat] <= busRData;
    if (strobe.install) begin
      tagMem[setIdx][victimQ] <= tagIn;
      for (int b = 0; b < LINE_WORDS; b++)
        dataMem[setIdx][victimQ][b] <= (BEAT_W'(b) == wordSel) ? installWord : fillBuf[b];
    end
    if (strobe.writeHit)
      dataMem[setIdx][hitWay][wordSel] <= mergeWord(dataMem[setIdx][hitWay][wordSel], wdataQ, beQ);
  end

  // R11: after invalidate-all nothing hits
  p_inv_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (hitVec == '0));

  // R9: a way dropped after a failed fill does not hit
  p_kill_invalid_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killVictim |=> !hitVec[victimQ]);

  // R3: a hit never occurs on an invalid way
  p_hit_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHit |-> validMem[setIdx][hitWay]);
endmodule

// File: rtl/wbdc_ctrl.sv
module wbdc_ctrl
  import wbdc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  input  logic      busAck,
  input  logic      busErr,
  output logic      busReq,
  output logic      busWrite,
  output logic      rspValid,
  output logic      rspHit,
  output logic      rspErr
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  ctlState_e         stQ, stD;
  logic [BEAT_W-1:0] beatQ, beatD;
  logic              rspSet, rspHitD, rspErrD;

  always_comb begin
    stD         = stQ;
    beatD       = beatQ;
    strobe      = '0;
    strobe.beat = beatQ;
    rspSet      = 1'b0;
    rspHitD     = 1'b0;
    rspErrD     = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stD = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (status.hit) begin
          rspSet  = 1'b1;
          rspHitD = 1'b1;
          if (status.isWrite) strobe.writeHit = 1'b1;
          else strobe.loadHitWord = 1'b1;
          stD = ST_IDLE;
        end else begin
          strobe.latchVictim = 1'b1;
          beatD = '0;
          stD = status.candDirty ? ST_COPYBACK : ST_FILL;
        end
      end
      ST_COPYBACK: begin
        strobe.copyback = 1'b1;
        if (busErr) begin
          rspSet  = 1'b1;
          rspErrD = 1'b1;
          beatD   = '0;
          stD     = ST_IDLE;
        end else if (busAck) begin
          if (beatQ == LAST_BEAT) begin
            beatD = '0;
            stD   = ST_FILL;
          end else begin
            beatD = beatQ + BEAT_W'(1);
          end
        end
      end
      ST_FILL: begin
        if (busErr) begin
          strobe.killVictim = 1'b1;
          rspSet  = 1'b1;
          rspErrD = 1'b1;
          beatD   = '0;
          stD     = ST_IDLE;
        end else if (busAck) begin
          strobe.captureBeat = 1'b1;
          if (beatQ == LAST_BEAT) begin
            beatD = '0;
            stD   = ST_INSTALL;
          end else begin
            beatD = beatQ + BEAT_W'(1);
          end
        end
      end
      ST_INSTALL: begin
        strobe.install = 1'b1;
        rspSet = 1'b1;
        stD    = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      beatQ    <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      stQ      <= stD;
      beatQ    <= beatD;
      rspValid <= rspSet;
      rspHit   <= rspHitD;
      rspErr   <= rspErrD;
    end
  end

  assign reqReady = (stQ == ST_IDLE);
  assign busReq   = (stQ == ST_COPYBACK) || (stQ == ST_FILL);
  assign busWrite = (stQ == ST_COPYBACK);

  // R2: a response is a single-cycle pulse
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2: a response leaves the block ready for the next request
  p_rsp_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  // R13: a beat without acknowledge or error holds the burst
  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !busErr) |=> (busReq && $stable(beatQ) && $stable(busWrite)));

  // R4: beats advance one at a time
  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && !busErr && beatQ != LAST_BEAT) |=> (beatQ == $past(beatQ) + BEAT_W'(1)));

  // R4: a line is installed only after a full error-free read burst
  p_install_after_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_INSTALL) |-> $past(stQ == ST_FILL && busAck && !busErr));

  // R9: a failed fill reports an error and no hit
  p_fill_err_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_FILL && busErr) |=> (rspValid && rspErr && !rspHit));
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import wbdc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7,
  parameter int WAYS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invAll,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWData,
  input  logic [BE_W-1:0]   reqByteEn,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [WORD_W-1:0] rspRData,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWData,
  input  logic [WORD_W-1:0] busRData,
  input  logic              busAck,
  input  logic              busErr
);
  dpStrobe_t strobe;
  dpStatus_t status;

  wbdc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .status   (status),
    .strobe   (strobe),
    .busAck   (busAck),
    .busErr   (busErr),
    .busReq   (busReq),
    .busWrite (busWrite),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspErr   (rspErr)
  );

  wbdc_datapath #(
    .ADDR_W   (ADDR_W),
    .SET_BITS (SET_BITS),
    .WAYS     (WAYS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .invAll    (invAll),
    .strobe    (strobe),
    .status    (status),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWData  (reqWData),
    .reqByteEn (reqByteEn),
    .busRData  (busRData),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .rspRData  (rspRData)
  );
endmodule

// File: tb/wb_dcache_tb.sv
module wb_dcache_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invAll = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWData = '0;
  logic [3:0]  reqByteEn = '0;
  logic        rspValid, rspHit, rspErr;
  logic [31:0] rspRData;
  logic        busReq, busWrite;
  logic [31:0] busAddr, busWData;
  logic [31:0] busRData = '0;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wb_dcache u_dut (
    .clk(clk), .rstN(rstN), .invAll(invAll),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqByteEn(reqByteEn),
    .rspValid(rspValid), .rspHit(rspHit), .rspErr(rspErr), .rspRData(rspRData),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .busAck(busAck), .busErr(busErr)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3 ^ {a[15:0], a[31:16]};
  endfunction

  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return {tag[20:0], set[6:0], word[1:0], 2'b00};
  endfunction

  function automatic logic [31:0] mergeB(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  // bus model
  logic [31:0] busMem [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  int  beatCnt = 0;
  int  cbDone = 0;
  int  fillDone = 0;
  bit  errArm = 1'b0;
  int  errBeat = 0;

  function automatic logic [31:0] memRd(input logic [31:0] a);
    return busMem.exists(a) ? busMem[a] : pat(a);
  endfunction

  always @(negedge clk) begin
    logic [31:0] a;
    busAck = 1'b0;
    busErr = 1'b0;
    if (rstN && busReq) begin
      a = busAddr + 32'(4 * beatCnt);
      if (errArm && beatCnt == errBeat) begin
        busErr  = 1'b1;
        errArm  = 1'b0;
        beatCnt = 0;
      end else begin
        busAck = 1'b1;
        if (busWrite) busMem[a] = busWData;
        else busRData = memRd(a);
        if (beatCnt == 3) begin
          beatCnt = 0;
          if (busWrite) cbDone++;
          else fillDone++;
        end else beatCnt++;
      end
    end
  end

  // scoreboard
  typedef struct {
    bit          isRead;
    bit          expHit;
    bit          expErr;
    logic [31:0] expData;
    int          expLat;
    int          acceptCyc;
    string       rq;
  } item_t;
  item_t sbQ[$];

  function automatic logic [31:0] expRd(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : pat(a);
  endfunction

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        check(rspHit == it.expHit, it.rq, "hit", 32'(rspHit), 32'(it.expHit));
        check(rspErr == it.expErr, it.rq, "err", 32'(rspErr), 32'(it.expErr));
        check(cyc - it.acceptCyc == it.expLat, it.rq, "latency",
              32'(cyc - it.acceptCyc), 32'(it.expLat));
        if (it.isRead && !it.expErr)
          check(rspRData == it.expData, it.rq, "read data", rspRData, it.expData);
      end
    end
  end

  task automatic doReq(input bit wr, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input bit eHit, input bit eErr,
                       input int eLat, input string rq);
    item_t it;
    @(negedge clk);
    it.isRead = !wr; it.expHit = eHit; it.expErr = eErr; it.expLat = eLat;
    it.acceptCyc = cyc + 1; it.rq = rq; it.expData = expRd(a);
    sbQ.push_back(it);
    if (wr && !eErr) shadow[a] = mergeB(expRd(a), d, be);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWData = d; reqByteEn = be;
    @(negedge clk);
    reqValid = 1'b0;
    while (sbQ.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input bit eHit, input int eLat, input string rq);
    doReq(1'b0, a, 32'h0, 4'h0, eHit, 1'b0, eLat, rq);
  endtask

  task automatic wrq(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                     input bit eHit, input int eLat, input string rq);
    doReq(1'b1, a, d, be, eHit, 1'b0, eLat, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cb0, fl0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R12", "reqReady in reset", 32'(reqReady), 32'd1);
    check(busReq == 1'b0, "R12", "busReq in reset", 32'(busReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R12", "rspValid after reset", 32'(rspValid), 32'd0);
    check(reqReady == 1'b1, "R12", "reqReady after reset", 32'(reqReady), 32'd1);

    // R4 / R1: clean fill, word 2 checks beat ordering
    rd(mk(1, 5, 2), 1'b0, 6, "R4");
    rd(mk(1, 5, 0), 1'b1, 1, "R2");
    // R5: partial write hit, no bus traffic
    cb0 = cbDone; fl0 = fillDone;
    wrq(mk(1, 5, 1), 32'h1122_3344, 4'b0101, 1'b1, 1, "R5");
    check(cbDone == cb0 && fillDone == fl0, "R5", "bus idle on write hit",
          32'(cbDone + fillDone), 32'(cb0 + fl0));
    rd(mk(1, 5, 1), 1'b1, 1, "R5");
    // R7: invalid ways used first
    rd(mk(2, 5, 0), 1'b0, 6, "R7");
    rd(mk(3, 5, 0), 1'b0, 6, "R7");
    rd(mk(4, 5, 0), 1'b0, 6, "R7");
    rd(mk(1, 5, 3), 1'b1, 1, "R7");
    // R8: round-robin picks way 0 (dirty tag 1)
    cb0 = cbDone;
    rd(mk(5, 5, 3), 1'b0, 10, "R8");
    check(cbDone == cb0 + 1, "R8", "one copyback", 32'(cbDone), 32'(cb0 + 1));
    // R8: next victim way 1 is clean; copied data comes back
    cb0 = cbDone;
    rd(mk(1, 5, 1), 1'b0, 6, "R8");
    check(cbDone == cb0, "R8", "no copyback for clean victim", 32'(cbDone), 32'(cb0));
    rd(mk(3, 5, 0), 1'b1, 1, "R7");
    rd(mk(2, 5, 0), 1'b0, 6, "R7");

    // R6: write miss allocates dirty line
    wrq(mk(9, 20, 3), 32'hCAFE_F00D, 4'hF, 1'b0, 6, "R6");
    rd(mk(9, 20, 3), 1'b1, 1, "R6");
    rd(mk(9, 20, 0), 1'b1, 1, "R6");

    // R11 / R3: invalidate all, dirty data lost
    cb0 = cbDone;
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
    shadow.delete(mk(9, 20, 3));
    rd(mk(9, 20, 3), 1'b0, 6, "R11");
    check(cbDone == cb0, "R11", "no copyback on invalidate", 32'(cbDone), 32'(cb0));
    rd(mk(4, 5, 0), 1'b0, 6, "R3");

    // R9: fill error leaves target invalid, neighbour intact
    rd(mk(41, 60, 0), 1'b0, 6, "R9");
    errArm = 1'b1; errBeat = 2;
    doReq(1'b0, mk(40, 60, 1), 32'h0, 4'h0, 1'b0, 1'b1, 4, "R9");
    rd(mk(41, 60, 0), 1'b1, 1, "R9");
    rd(mk(40, 60, 1), 1'b0, 6, "R9");

    // R10: copyback error keeps the dirty line
    wrq(mk(50, 70, 2), 32'h0BAD_BEEF, 4'hF, 1'b0, 6, "R10");
    rd(mk(51, 70, 0), 1'b0, 6, "R10");
    rd(mk(52, 70, 0), 1'b0, 6, "R10");
    rd(mk(53, 70, 0), 1'b0, 6, "R10");
    errArm = 1'b1; errBeat = 1;
    doReq(1'b0, mk(54, 70, 0), 32'h0, 4'h0, 1'b0, 1'b1, 3, "R13");
    rd(mk(50, 70, 2), 1'b1, 1, "R10");
    rd(mk(54, 70, 0), 1'b0, 10, "R10");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule